// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block is a watchdog made of a fixed binary prescale counter followed by a selectable power-of-two postscaler. It advances only on cycles where an always-on, low-frequency clock enable is high, so it keeps running while the core is idle or asleep. When the selected period has elapsed, it issues one of two one-cycle pulses. If the core is executing, the pulse is a reset request. If the core is idle or asleep, the pulse is a wake request.

The count returns to zero after any of several events:
- an executed clear-watchdog instruction;
- an executed sleep instruction;
- a clock-loss report from the fail-safe monitor, but only while that monitor is enabled;
- a write to the internal-oscillator frequency field, but only while that oscillator drives the system clock.

Deasserting the enable also holds the count at zero. After either pulse the count starts over from zero.

Top module: `mode_wdt`

## Requirements
- R1: While `rst_n` is low, both `wake_pulse` and `rst_pulse` are low. After reset is released, the first timeout takes a full period.
- R2: With no clear event, a timeout occurs on the `BASE_CNT * 2^post_sel`-th cycle with `tick_en` high, where `BASE_CNT = 2^BASE_LOG2`. Cycles with `tick_en` low do not advance the count.
- R3: A timeout in a cycle where `core_active` is 0 raises `wake_pulse` for exactly the next cycle, and `rst_pulse` stays low.
- R4: A timeout in a cycle where `core_active` is 1 raises `rst_pulse` for exactly the next cycle, and `wake_pulse` stays low.
- R5: Each pulse lasts one cycle, and counting restarts from zero after a timeout.
- R6: A high `clrwdt_stb` resets the count to zero.
- R7: A high `sleep_stb` resets the count to zero.
- R8: A high `ckfail_stb` resets the count only when `fscm_en` is 1. Otherwise it has no effect on the timing of the next pulse.
- R9: A high `freq_wr_stb` resets the count only when `intosc_sys` is 1. Otherwise it has no effect on the timing of the next pulse.
- R10: While `wdt_en` is 0, the count is held at zero and no pulse is issued.
- R11: A clear event in the same cycle as the expiring tick wins: no pulse is issued, and the count restarts from zero.
- R12: `wake_pulse` and `rst_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Low-frequency clock enable; one count per high cycle |
| wdt_en | input | 1 | Watchdog enable |
| clrwdt_stb | input | 1 | Clear-watchdog instruction executed |
| sleep_stb | input | 1 | Sleep instruction executed |
| ckfail_stb | input | 1 | Fail-safe monitor reports loss of the selected clock |
| fscm_en | input | 1 | Fail-safe monitor enabled |
| freq_wr_stb | input | 1 | Internal-oscillator frequency field written |
| intosc_sys | input | 1 | Internal oscillator is the system clock |
| core_active | input | 1 | 1 = core executing (run), 0 = idle or sleep |
| post_sel | input | SEL_W | Postscaler exponent N, ratio 2^N |
| wake_pulse | output | 1 | One-cycle wake request |
| rst_pulse | output | 1 | One-cycle watchdog reset request |

## Verification
The collision of interest is a clear event landing in the same cycle as the final tick of a period. The bench provokes it by tracking the elapsed tick count and raising one of the clear sources exactly on the expiring tick. It then expects no pulse on the following cycle and a full period before the next timeout. It also lets a clock-loss report or frequency write arrive with its gating condition false at that same point, and expects the pulse to appear on time.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg
// Shared definitions for the mode-aware watchdog.
// Assumes: consumers import it before declaring ports.
package wdt_pkg;

    // Outcome of an expiring period.
    typedef enum logic [1:0] {
        OUT_NONE  = 2'b00,
        OUT_WAKE  = 2'b01,
        OUT_RESET = 2'b10
    } wdt_outcome_e;

    // Derive the postscaler width from the select width.
    function automatic int unsigned post_width(input int unsigned sel_w);
        return 1 << sel_w;
    endfunction

endpackage

// File: rtl/wdt_clear_ctrl.sv
// Module wdt_clear_ctrl
// Merges every event that restarts the watchdog into a single clear.
// Assumes: all strobes are one-cycle, synchronous to clk.
module wdt_clear_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_en,
    input  logic clrwdt_stb,
    input  logic sleep_stb,
    input  logic ckfail_stb,
    input  logic fscm_en,
    input  logic freq_wr_stb,
    input  logic intosc_sys,
    output logic clr
);

    logic ckfail_qual;
    logic freq_qual;

    // Qualify the gated sources and merge all clear causes.
    always_comb begin
        ckfail_qual = ckfail_stb & fscm_en;
        freq_qual   = freq_wr_stb & intosc_sys;
        clr         = clrwdt_stb | sleep_stb | ckfail_qual | freq_qual | ~wdt_en;
    end

    // A clock-loss report without an enabled monitor must not clear.
    assert_ckfail_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ckfail_stb && !fscm_en && !clrwdt_stb && !sleep_stb && !freq_qual && wdt_en) |-> !clr);

    // A frequency write while another clock runs the system must not clear.
    assert_freq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_wr_stb && !intosc_sys && !clrwdt_stb && !sleep_stb && !ckfail_qual && wdt_en) |-> !clr);

endmodule

// File: rtl/wdt_counter.sv
// Module wdt_counter
// Prescale counter of 2^BASE_LOG2 ticks feeding a postscale counter that
// expires after 2^post_sel prescale wraps.
// Assumes: BASE_LOG2 >= 1, so two expiries are never on adjacent cycles.
module wdt_counter #(
    parameter int unsigned BASE_LOG2 = 7,
    parameter int unsigned SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clr,
    input  logic [SEL_W-1:0] post_sel,
    output logic             expire
);

    localparam int unsigned POST_W = wdt_pkg::post_width(SEL_W);

    logic [BASE_LOG2-1:0] base_q;
    logic [POST_W-1:0]    post_q;
    logic [POST_W-1:0]    post_limit;
    logic                 base_last;
    logic                 post_done;

    // Decide whether the current tick ends the period.
    always_comb begin
        post_limit = (POST_W'(1) << post_sel) - POST_W'(1);
        base_last  = &base_q;
        post_done  = (post_q >= post_limit);
        expire     = tick_en & base_last & post_done & ~clr;
    end

    // Advance, clear or restart the two counter stages.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || expire) begin
            base_q <= '0;
            post_q <= '0;
        end else if (tick_en) begin
            base_q <= base_q + 1'b1;
            if (base_last) begin
                post_q <= post_q + 1'b1;
            end
        end
    end

    // Any clear leaves both stages at zero.
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (base_q == '0 && post_q == '0));

    // Without a tick or a clear the prescale stage does not move.
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clr) |=> $stable(base_q));

    // An expiry restarts counting from zero.
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (base_q == '0 && post_q == '0));

endmodule

// File: rtl/wdt_outcome.sv
// Module wdt_outcome
// Turns an expiry into a registered one-cycle wake or reset request,
// chosen by whether the core was executing in the expiry cycle.
// Assumes: expire is never high on two adjacent cycles.
module wdt_outcome (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic core_active,
    output logic wake_pulse,
    output logic rst_pulse
);

    wdt_pkg::wdt_outcome_e kind;

    // Classify the expiry by the core state.
    always_comb begin
        if (!expire)          kind = wdt_pkg::OUT_NONE;
        else if (core_active) kind = wdt_pkg::OUT_RESET;
        else                  kind = wdt_pkg::OUT_WAKE;
    end

    // Register the classified request as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
            rst_pulse  <= 1'b0;
        end else begin
            wake_pulse <= (kind == wdt_pkg::OUT_WAKE);
            rst_pulse  <= (kind == wdt_pkg::OUT_RESET);
        end
    end

    assert_idle_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !core_active) |=> (wake_pulse && !rst_pulse));

    assert_run_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && core_active) |=> (rst_pulse && !wake_pulse));

    assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse || rst_pulse) |=> !(wake_pulse || rst_pulse));

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_pulse && rst_pulse));

endmodule

// File: rtl/mode_wdt.sv
// Module mode_wdt
// Watchdog whose timeout wakes an idle or sleeping core and resets a running one.
// Assumes: tick_en comes from an always-on low-frequency source; all
// inputs are synchronous to clk; reset is synchronous, active low.
module mode_wdt #(
    parameter int unsigned BASE_LOG2 = 7,
    parameter int unsigned SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wdt_en,
    input  logic             clrwdt_stb,
    input  logic             sleep_stb,
    input  logic             ckfail_stb,
    input  logic             fscm_en,
    input  logic             freq_wr_stb,
    input  logic             intosc_sys,
    input  logic             core_active,
    input  logic [SEL_W-1:0] post_sel,
    output logic             wake_pulse,
    output logic             rst_pulse
);

    logic clr;
    logic expire;

    wdt_clear_ctrl u_clear (
        .clk         (clk),
        .rst_n       (rst_n),
        .wdt_en      (wdt_en),
        .clrwdt_stb  (clrwdt_stb),
        .sleep_stb   (sleep_stb),
        .ckfail_stb  (ckfail_stb),
        .fscm_en     (fscm_en),
        .freq_wr_stb (freq_wr_stb),
        .intosc_sys  (intosc_sys),
        .clr         (clr)
    );

    wdt_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .SEL_W     (SEL_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .clr      (clr),
        .post_sel (post_sel),
        .expire   (expire)
    );

    wdt_outcome u_outcome (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .core_active (core_active),
        .wake_pulse  (wake_pulse),
        .rst_pulse   (rst_pulse)
    );

    // A clear, including a disabled watchdog, suppresses the next pulse.
    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!wake_pulse && !rst_pulse));

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> (!wake_pulse && !rst_pulse));

endmodule

// File: tb/mode_wdt_bench.sv
module mode_wdt_bench;

    localparam int BASE_LOG2 = 2;
    localparam int SEL_W     = 4;
    localparam int BASE_CNT  = 1 << BASE_LOG2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, wdt_en = 1'b0, clrwdt_stb = 1'b0, sleep_stb = 1'b0;
    logic ckfail_stb = 1'b0, fscm_en = 1'b0, freq_wr_stb = 1'b0, intosc_sys = 1'b0;
    logic core_active = 1'b0;
    logic [SEL_W-1:0] post_sel = '0;
    logic wake_pulse, rst_pulse;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    int  m_cnt = 0;
    bit  exp_wake = 1'b0;
    bit  exp_rst = 1'b0;
    bit  prev_pulse = 1'b0;
    string tag = "R1";

    mode_wdt #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_mode_wdt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wdt_en(wdt_en),
        .clrwdt_stb(clrwdt_stb), .sleep_stb(sleep_stb), .ckfail_stb(ckfail_stb),
        .fscm_en(fscm_en), .freq_wr_stb(freq_wr_stb), .intosc_sys(intosc_sys),
        .core_active(core_active), .post_sel(post_sel),
        .wake_pulse(wake_pulse), .rst_pulse(rst_pulse)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    function automatic int period(input logic [SEL_W-1:0] s);
        return BASE_CNT << s;
    endfunction

    task automatic check_outputs();
        checks++;
        if (wake_pulse !== exp_wake || rst_pulse !== exp_rst) begin
            failures++;
            $display("FAIL %s: wake=%0b rst=%0b expected wake=%0b rst=%0b at cycle %0d",
                     tag, wake_pulse, rst_pulse, exp_wake, exp_rst, cycles);
        end
        checks++;
        if (wake_pulse === 1'b1 && rst_pulse === 1'b1) begin
            failures++;
            $display("FAIL R12: wake=1 rst=1 expected at most one high");
        end
    endtask

    // One cycle: check results of the last edge, apply inputs, predict the next edge.
    task automatic step(input bit rn, input bit ten, input bit en, input bit clw,
                        input bit slp, input bit ckf, input bit fsm, input bit frq,
                        input bit ios, input bit act, input logic [SEL_W-1:0] sel);
        bit clr;
        bit last;
        @(negedge clk);
        check_outputs();
        rst_n = rn; tick_en = ten; wdt_en = en; clrwdt_stb = clw; sleep_stb = slp;
        ckfail_stb = ckf; fscm_en = fsm; freq_wr_stb = frq; intosc_sys = ios;
        core_active = act; post_sel = sel;
        clr  = clw | slp | (ckf & fsm) | (frq & ios) | ~en;
        last = ten && (m_cnt + 1 == period(sel));
        prev_pulse = exp_wake | exp_rst;
        exp_wake = 1'b0;
        exp_rst  = 1'b0;
        if (!rn) begin
            m_cnt = 0; tag = "R1";
        end else if (clr) begin
            m_cnt = 0;
            if (last)      tag = "R11";
            else if (!en)  tag = "R10";
            else if (slp)  tag = "R7";
            else if (clw)  tag = "R6";
            else if (ckf)  tag = "R8";
            else           tag = "R9";
        end else if (ten) begin
            if (last) begin
                m_cnt = 0;
                exp_wake = !act;
                exp_rst  = act;
                tag = act ? "R4" : "R3";
            end else begin
                m_cnt++;
                tag = prev_pulse ? "R5" : ((ckf || frq) ? "R8_R9" : "R2");
            end
        end else begin
            tag = prev_pulse ? "R5" : "R2";
        end
    endtask

    // Run a clean enabled period, ticking each cycle.
    task automatic run_ticks(input int n, input bit act, input logic [SEL_W-1:0] sel);
        for (int i = 0; i < n; i++) step(1, 1, 1, 0, 0, 0, 0, 0, 0, act, sel);
    endtask

    initial begin : watchdog
        while (!done && cycles < 150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int r;
        logic [SEL_W-1:0] sel;
        bit act;
        void'($urandom(32'd4242));
        // R1: reset holds outputs low
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 0, 0, 0, 0, 0, 1, 4'd0);
        // R2/R4: full period right after reset, run mode -> reset pulse
        run_ticks(period(4'd1) + 3, 1'b1, 4'd1);
        // R3: idle mode -> wake pulse
        step(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 4'd2);
        run_ticks(period(4'd2) + 2, 1'b0, 4'd2);
        // R11: clear on the expiring tick (sleep strobe)
        step(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 4'd1);
        run_ticks(period(4'd1) - 1, 1'b0, 4'd1);
        step(1, 1, 1, 0, 1, 0, 0, 0, 0, 0, 4'd1);
        run_ticks(period(4'd1) + 1, 1'b0, 4'd1);
        // R8: ungated clock-loss on the expiring tick is ignored
        step(1, 1, 1, 1, 0, 0, 0, 0, 0, 1, 4'd1);
        run_ticks(period(4'd1) - 1, 1'b1, 4'd1);
        step(1, 1, 1, 0, 0, 1, 0, 0, 0, 1, 4'd1);
        run_ticks(3, 1'b1, 4'd1);
        // R9: ungated frequency write on the expiring tick is ignored
        step(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 4'd0);
        run_ticks(period(4'd0) - 1, 1'b0, 4'd0);
        step(1, 1, 1, 0, 0, 0, 0, 1, 0, 0, 4'd0);
        run_ticks(3, 1'b0, 4'd0);
        // R8/R9 gated versions clear mid-period
        step(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 4'd2);
        run_ticks(10, 1'b0, 4'd2);
        step(1, 1, 1, 0, 0, 1, 1, 0, 0, 0, 4'd2);
        run_ticks(10, 1'b0, 4'd2);
        step(1, 1, 1, 0, 0, 0, 0, 1, 1, 0, 4'd2);
        run_ticks(period(4'd2) + 2, 1'b0, 4'd2);
        // R10: disabled watchdog stays quiet
        for (int i = 0; i < 3 * period(4'd0); i++) step(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 4'd0);
        // Random phase (R2..R12)
        sel = 4'd0;
        act = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            bit ten, en, clw, slp, ckf, fsm, frq, ios;
            logic [SEL_W-1:0] nsel;
            r = int'($urandom_range(0, 999));
            nsel = sel;
            ten = ($urandom_range(0, 3) != 0);
            en  = ($urandom_range(0, 499) != 0);
            clw = (r < 3);
            slp = (r >= 3 && r < 5);
            ckf = (r >= 5 && r < 9);
            frq = (r >= 9 && r < 13);
            fsm = $urandom_range(0, 1);
            ios = $urandom_range(0, 1);
            if ($urandom_range(0, 299) == 0) act = ~act;
            // aim a clear at the expiring tick now and then (R11)
            if (ten && m_cnt + 1 == period(sel) && $urandom_range(0, 3) == 0) clw = 1'b1;
            if (clw) nsel = 4'($urandom_range(0, 5));
            step(1, ten, en, clw, slp, ckf, fsm, frq, ios, act, nsel);
            sel = nsel;
        end
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, sel);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule